// File: doc/BRIEF.md
# Redirected Interrupt Pin Service Unit

This block watches a set of external interrupt pins and turns them into interrupt messages. Each pin has an entry in a redirection table, which arrives as an input array; the entry sets the pin's polarity, trigger kind, mask, target and vector. The unit keeps a pending bit per pin, which is the pin level after polarity correction. For level-triggered pins it also keeps a remote-pending bit. While that bit is set, the source is in service downstream and the pin is not sent again. An end-of-interrupt notice that carries a vector releases every level pin whose entry holds that vector. Any released pin that is still pending and unmasked is sent again.

Messages leave through a single valid/ready port. A message is loaded into a one-deep output stage. While `msg_valid` is high and `msg_ready` is low, the message is held unchanged. A handshake happens on any clock edge where both are high. On that same edge the stage may load the next message, so the port can move one message per cycle. When several pins compete, the lowest-numbered pin is loaded first.

A per-pin re-evaluate strobe lets the surrounding logic ask for a level pin to be checked again. It is meant for use after that pin's table entry has been rewritten, for example after it was unmasked.

Top module: `irq_route_svc`

## Requirements
- R1: Entry bit positions are vector [7:0], delivery mode [10:8], destination mode [11], polarity [12], trigger kind [13] (1 = level, 0 = edge), mask [14] and destination [22:15]. A pin's pending bit is the pin level XOR the polarity bit, so polarity 1 means active-low.
- R2: An edge-triggered pin produces exactly one message per rising edge of its pending bit, held as a request until it is sent. A falling edge produces no message.
- R3: A level-triggered pin is sent when it is pending and its remote-pending bit is clear. Loading its message sets remote-pending, and no further message comes from that pin while remote-pending stays set.
- R4: A pin whose mask bit is set is never sent. A rising edge or level assertion seen while the pin is masked is discarded.
- R5: An end-of-interrupt with vector V clears remote-pending on every level pin whose vector equals V. Each such pin that is still pending and unmasked is sent again, and one whose input has dropped is not.
- R6: A message copies destination, vector, destination mode and trigger kind from the entry. The 11-bit delivery field carries the 3-bit delivery mode in bits [10:8], with zeros below.
- R7: When several pins are eligible, the lowest-numbered pin is loaded first. One message leaves per handshake.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field stays stable.
- R9: A re-evaluate strobe on a level pin that is pending, unmasked and not remote-pending causes a message. A strobe while remote-pending is set causes none.
- R10: After reset, `msg_valid` is low and all pending, request and remote-pending state is clear.
- R11: When the output stage is free, a message appears after the second clock edge following the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Raw interrupt pin levels |
| tbl | input | NPINS x 23 | Redirection entries, one per pin |
| recheck | input | NPINS | Per-pin re-evaluate strobe |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Destination |
| msg_vector | output | 8 | Vector |
| msg_dest_mode | output | 1 | Destination mode |
| msg_trig | output | 1 | Trigger kind (1 = level) |
| msg_dlv | output | 11 | Delivery mode shifted left by 8 |

## Verification
The bench targets several corner cases. A level pin must stay silent until an end-of-interrupt releases it; a design that re-armed it anyway would flood the port with duplicates. An end-of-interrupt that arrives after the pin has dropped must produce no message; a design that re-sent on release alone would deliver a phantom interrupt. Two pins rising on the same edge must leave in index order; a wrong picker would swap or lose one. The bench also stalls the port while a second request arrives, and a design that did not hold its output would change the message under stall. Finally it checks that a masked assertion stays dead after unmasking until the re-evaluate strobe, that one end-of-interrupt releases two pins sharing a vector, and that the delivery mode lands at the shifted position.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int VEC_W  = 8;
  parameter int DEST_W = 8;
  parameter int DLV_W  = 3;
  parameter int DLV_SH = 8;
  localparam int MSG_DLV_W = DLV_W + DLV_SH;

  // Field order is significant: it fixes the bit positions of an entry.
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              lvl;
    logic              pol;
    logic              dmode;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vector;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  typedef struct packed {
    logic [DEST_W-1:0]    dest;
    logic [VEC_W-1:0]     vector;
    logic                 dmode;
    logic                 trig;
    logic [MSG_DLV_W-1:0] dlv;
  } msg_t;
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track
  import irq_route_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  entry_t ent,
  input  logic   recheck,
  input  logic   eoi_hit,
  input  logic   grant,
  output logic   elig,
  output logic   rirr
);
  logic pend, edge_req, arm;
  logic pend_d, rise, edge_req_d, arm_d, rirr_d, lvl_evt;

  always_comb begin
    pend_d     = pin ^ ent.pol;
    rise       = pend_d & ~pend;
    edge_req_d = ((edge_req & ~grant) | rise) & ~ent.mask & ~ent.lvl;
    if (!ent.lvl)     rirr_d = 1'b0;
    else if (grant)   rirr_d = 1'b1;
    else if (eoi_hit) rirr_d = 1'b0;
    else              rirr_d = rirr;
    lvl_evt = ((rise | recheck) & ~rirr) | eoi_hit;
    arm_d   = ((arm & ~grant) | lvl_evt) & ent.lvl & ~ent.mask & pend_d & ~rirr_d;
    if (ent.lvl) elig = arm & pend & ~rirr & ~ent.mask;
    else         elig = edge_req & ~ent.mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      edge_req <= 1'b0;
      arm      <= 1'b0;
      rirr     <= 1'b0;
    end else begin
      pend     <= pend_d;
      edge_req <= edge_req_d;
      arm      <= arm_d;
      rirr     <= rirr_d;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NPINS = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    onehot = req & (~req + NPINS'(1));
    any    = |req;
    idx    = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/irq_msg_stage.sv
module irq_msg_stage
  import irq_route_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_any,
  input  entry_t sel_ent,
  input  logic   out_ready,
  output logic   can_load,
  output logic   out_valid,
  output msg_t   out_msg
);
  assign can_load = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else if (can_load) begin
      out_valid <= load_any;
      if (load_any) begin
        out_msg.dest   <= sel_ent.dest;
        out_msg.vector <= sel_ent.vector;
        out_msg.dmode  <= sel_ent.dmode;
        out_msg.trig   <= sel_ent.lvl;
        out_msg.dlv    <= {sel_ent.dlv, {DLV_SH{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/irq_route_svc.sv
module irq_route_svc
  import irq_route_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPINS-1:0]               pin_in,
  input  logic [NPINS-1:0][ENT_W-1:0]    tbl,
  input  logic [NPINS-1:0]               recheck,
  input  logic                           eoi_valid,
  input  logic [VEC_W-1:0]               eoi_vector,
  output logic                           msg_valid,
  input  logic                           msg_ready,
  output logic [DEST_W-1:0]              msg_dest,
  output logic [VEC_W-1:0]               msg_vector,
  output logic                           msg_dest_mode,
  output logic                           msg_trig,
  output logic [MSG_DLV_W-1:0]           msg_dlv
);
  logic [NPINS-1:0] elig, rirr, grant, pick_oh, mask_vec, lvl_vec;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, can_load;
  entry_t           sel_ent;
  msg_t             out_msg;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    entry_t ent;
    logic   hit;
    assign ent         = entry_t'(tbl[g]);
    assign hit         = eoi_valid & ent.lvl & (ent.vector == eoi_vector);
    assign mask_vec[g] = ent.mask;
    assign lvl_vec[g]  = ent.lvl;
    irq_pin_track u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_in[g]),
      .ent     (ent),
      .recheck (recheck[g]),
      .eoi_hit (hit),
      .grant   (grant[g]),
      .elig    (elig[g]),
      .rirr    (rirr[g])
    );
  end

  irq_prio_pick #(.NPINS(NPINS)) u_pick (
    .req    (elig),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  assign grant   = can_load ? pick_oh : '0;
  assign sel_ent = entry_t'(tbl[pick_idx]);

  irq_msg_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_any  (pick_any),
    .sel_ent   (sel_ent),
    .out_ready (msg_ready),
    .can_load  (can_load),
    .out_valid (msg_valid),
    .out_msg   (out_msg)
  );

  assign msg_dest      = out_msg.dest;
  assign msg_vector    = out_msg.vector;
  assign msg_dest_mode = out_msg.dmode;
  assign msg_trig      = out_msg.trig;
  assign msg_dlv       = out_msg.dlv;
endmodule

// File: rtl/irq_route_svc_chk.sv
module irq_route_svc_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [7:0]       msg_dest,
  input logic [NPINS-1:0] grant,
  input logic [NPINS-1:0] elig,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] lvl_vec,
  input logic [NPINS-1:0] rirr
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest))) // R8
    else $error("stall hold violated");

  AST_ONE_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) // R7
    else $error("more than one pin granted");

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((elig & (grant - NPINS'(1))) == '0)) // R7
    else $error("lower pin skipped");

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & mask_vec) == '0)) // R4
    else $error("masked pin granted");

  AST_RIRR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & lvl_vec) != '0) |=> ((rirr & $past(grant & lvl_vec)) == $past(grant & lvl_vec))) // R3
    else $error("remote-pending not set");
endmodule

bind irq_route_svc irq_route_svc_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_dest   (msg_dest),
  .grant      (grant),
  .elig       (elig),
  .mask_vec   (mask_vec),
  .lvl_vec    (lvl_vec),
  .rirr       (rirr)
);

// File: tb/test_irq_route_svc.sv
module test_irq_route_svc;
  localparam int NP = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        pin_in = '0;
  logic [NP-1:0][22:0]  tbl;
  logic [NP-1:0]        recheck = '0;
  logic                 eoi_valid = 1'b0;
  logic [7:0]           eoi_vector = '0;
  logic                 msg_valid;
  logic                 msg_ready = 1'b1;
  logic [7:0]           msg_dest, msg_vector;
  logic                 msg_dest_mode, msg_trig;
  logic [10:0]          msg_dlv;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_route_svc #(.NPINS(NP)) i_irq_route_svc (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tbl(tbl), .recheck(recheck),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
    .msg_dest_mode(msg_dest_mode), .msg_trig(msg_trig), .msg_dlv(msg_dlv)
  );

  // {dest, mask, level, pol, dmode, dlv, vector}
  function automatic logic [22:0] mk(input logic [7:0] dest, input logic msk,
      input logic lvl, input logic pol, input logic dm, input logic [2:0] dlv,
      input logic [7:0] vec);
    return {dest, msk, lvl, pol, dm, dlv, vec};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic base_cfg();
    for (int i = 0; i < NP; i++) tbl[i] = mk(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h10);
    tbl[0] = mk(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h20);
    tbl[1] = mk(8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h31);
    tbl[2] = mk(8'h03, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 8'h42);
    tbl[3] = mk(8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h53);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; recheck = '0; eoi_valid = 1'b0; msg_ready = 1'b1;
    pin_in = 8'b0000_0100;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  // {pins[3:0], eoi_v, eoi_vec, exp_v, exp_vec}
  localparam int NROW = 18;
  localparam logic [21:0] ROWS [NROW] = '{
    {4'b0101, 1'b0, 8'h00, 1'b0, 8'h00},  // R2 pin0 rises
    {4'b0101, 1'b0, 8'h00, 1'b1, 8'h20},  // R2 R11 message
    {4'b0100, 1'b0, 8'h00, 1'b0, 8'h00},  // R2 falling edge silent
    {4'b0110, 1'b0, 8'h00, 1'b0, 8'h00},  // R3 level pin1 asserts
    {4'b0110, 1'b0, 8'h00, 1'b1, 8'h31},  // R3 sent
    {4'b0110, 1'b0, 8'h00, 1'b0, 8'h00},  // R3 remote-pending blocks repeat
    {4'b0110, 1'b1, 8'h31, 1'b0, 8'h00},  // R5 eoi
    {4'b0110, 1'b0, 8'h00, 1'b1, 8'h31},  // R5 re-sent
    {4'b0100, 1'b1, 8'h31, 1'b0, 8'h00},  // R5 eoi after drop
    {4'b0100, 1'b0, 8'h00, 1'b0, 8'h00},  // R5 no phantom
    {4'b0000, 1'b0, 8'h00, 1'b0, 8'h00},  // R1 active-low pin2 asserts
    {4'b0000, 1'b0, 8'h00, 1'b1, 8'h42},  // R1 sent
    {4'b0011, 1'b0, 8'h00, 1'b0, 8'h00},  // R7 two pins at once
    {4'b0011, 1'b0, 8'h00, 1'b1, 8'h20},  // R7 lowest first
    {4'b0011, 1'b0, 8'h00, 1'b1, 8'h31},  // R7 then next
    {4'b0011, 1'b0, 8'h00, 1'b0, 8'h00},  // R7 nothing more
    {4'b1011, 1'b0, 8'h00, 1'b0, 8'h00},  // R4 masked edge pin3
    {4'b1011, 1'b0, 8'h00, 1'b0, 8'h00}   // R4 still silent
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    base_cfg();
    do_reset();
    chk("R10 valid after reset", 32'(msg_valid), 32'd0);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      pin_in     = {4'b0000, ROWS[r][21:18]};
      eoi_valid  = ROWS[r][17];
      eoi_vector = ROWS[r][16:9];
      tick();
      eoi_valid = 1'b0;
      chk($sformatf("R2/R3/R5/R7 row %0d valid", r), 32'(msg_valid), 32'(ROWS[r][8]));
      if (ROWS[r][8]) chk($sformatf("R1/R7 row %0d vector", r), 32'(msg_vector), 32'(ROWS[r][7:0]));
    end

    // R6 field copy and delivery shift
    base_cfg();
    tbl[5] = mk(8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101, 8'h66);
    do_reset();
    pin_in[5] = 1'b1;
    tick(); tick();
    chk("R6 valid", 32'(msg_valid), 32'd1);
    chk("R6 dest", 32'(msg_dest), 32'h0A5);
    chk("R6 vector", 32'(msg_vector), 32'h066);
    chk("R6 dest mode", 32'(msg_dest_mode), 32'd1);
    chk("R6 trig", 32'(msg_trig), 32'd1);
    chk("R6 delivery shifted", 32'(msg_dlv), 32'h500);

    // R8 back-pressure
    base_cfg();
    do_reset();
    msg_ready = 1'b0;
    pin_in = 8'b0000_0111;
    tick(); tick();
    for (int k = 0; k < 3; k++) begin
      chk("R8 held valid", 32'(msg_valid), 32'd1);
      chk("R8 held vector", 32'(msg_vector), 32'h20);
      tick();
    end
    msg_ready = 1'b1;
    tick();
    chk("R8 next after handshake", 32'(msg_vector), 32'h31);
    chk("R8 next valid", 32'(msg_valid), 32'd1);
    tick();
    chk("R8 drained", 32'(msg_valid), 32'd0);

    // R4 / R9 masked assertion, unmask, recheck
    base_cfg();
    tbl[1][14] = 1'b1;
    do_reset();
    pin_in = 8'b0000_0110;
    tick(); tick(); tick();
    chk("R4 masked level silent", 32'(msg_valid), 32'd0);
    tbl[1][14] = 1'b0;
    tick(); tick();
    chk("R4 discarded after unmask", 32'(msg_valid), 32'd0);
    recheck[1] = 1'b1;
    tick();
    recheck[1] = 1'b0;
    tick();
    chk("R9 recheck sends", 32'(msg_valid), 32'd1);
    chk("R9 recheck vector", 32'(msg_vector), 32'h31);
    tick();
    recheck[1] = 1'b1;
    tick();
    recheck[1] = 1'b0;
    tick();
    chk("R9 recheck ignored while remote-pending", 32'(msg_valid), 32'd0);

    // R5 shared vector on two level pins
    base_cfg();
    tbl[1] = mk(8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h77);
    tbl[6] = mk(8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h77);
    do_reset();
    pin_in = 8'b0100_0110;
    tick(); tick();
    chk("R5 first pin", 32'(msg_dest), 32'h02);
    tick();
    chk("R5 second pin", 32'(msg_dest), 32'h07);
    tick();
    chk("R5 both in service", 32'(msg_valid), 32'd0);
    eoi_valid = 1'b1; eoi_vector = 8'h77;
    tick();
    eoi_valid = 1'b0;
    tick();
    chk("R5 resend first", 32'(msg_dest), 32'h02);
    chk("R5 resend valid", 32'(msg_valid), 32'd1);
    tick();
    chk("R5 resend second", 32'(msg_dest), 32'h07);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule